// File: doc/BRIEF.md
# Read Data-Float Turnaround Gate

This block sits in front of an external memory bus that several chip selects share. A slow device keeps driving the data lines for a while after its read strobe returns high. The block measures that interval from the strobe's rising edge. It holds off any access that could collide with the device's late data until that device's float time has passed, plus one more bus-turnaround clock.

Each chip select has its own settings: a float count from 0 to 15 clocks and an overlap enable. When overlap is enabled, the setup phase of the next access counts toward the float wait, so that access stalls for fewer cycles. The controller also carries a page-mode enable and a page-size code for each chip select. It reports both for the chip select being requested, and they have no effect on the timing.

Accesses arrive on a valid/ready handshake. An access is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold `req_cs`, `req_write` and `req_setup` stable. `req_ready` depends only on the current request and on registered state, so the requester may raise `req_valid` without waiting for ready.

Top module: `turnaround_ctl`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. It clears any open float window, so `float_busy` is low in the cycle after a reset edge and a following request sees no stall.
- R2: The read strobe has a rising edge when it is sampled low at one clock edge and high at the next. That edge opens a window of F+1 cycles for the chip select on `rd_cs`. F is that chip select's 4-bit field `cfg_float[4*cs +: 4]`. `float_busy` stays high while the window is open.
- R3: With the window owner's overlap bit (`cfg_opt[cs]`) at 0, a request presented in the first cycle after the rising edge is refused for exactly F+1 cycles when it is a read to another chip select.
- R4: With the owner's overlap bit at 1, such a request is refused for max(0, F+1-S) cycles, where S is `req_setup`.
- R5: A read request to the chip select that owns the window is never held by that window.
- R6: A write request is held by the window under the rules of R3 and R4, even when it targets the owning chip select.
- R7: When no window is open, `req_ready` equals `req_valid`.
- R8: For the chip select on `req_cs`, `acc_page_mode` shows its `cfg_page_en` bit. `acc_page_bytes` shows the decoded page size from `cfg_page_size[2*cs +: 2]`, where code 0 gives 4, code 1 gives 8, code 2 gives 16 and code 3 gives 32 bytes. The page settings have no effect on stall counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_float | input | NUM_CS*4 | Float clock count for each chip select |
| cfg_opt | input | NUM_CS | Overlap enable for each chip select |
| cfg_page_en | input | NUM_CS | Page-mode enable for each chip select |
| cfg_page_size | input | NUM_CS*2 | Page-size code for each chip select |
| rd_strobe | input | 1 | Read control strobe; rising edge ends a read |
| rd_cs | input | CSW | Chip select of the read in progress |
| req_valid | input | 1 | Next access is pending |
| req_ready | output | 1 | Access may take the bus |
| req_cs | input | CSW | Chip select of the next access |
| req_write | input | 1 | Next access is a write |
| req_setup | input | SETUP_W | Setup length of the next access in clocks |
| float_busy | output | 1 | A float window is open |
| acc_page_mode | output | 1 | Page-mode enable of `req_cs` |
| acc_page_bytes | output | 6 | Page size in bytes of `req_cs` |

## Verification
The bench counts the exact number of refused cycles for each request. It covers float counts of 0, 3, 5 and 15, both overlap settings, and setup lengths below, equal to and above F+1. A missing turnaround cycle or an off-by-one in the setup comparison would each change a count by one. A design that let a same-CS write through would show zero stalls where F+1 are expected. A design that still honoured the window after reset would stall the first request after a reset pulse. Changing the page size and then repeating a scenario would expose any leak of the page settings into the stall count.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  localparam int FLOAT_W = 4;
  localparam int PSIZE_W = 2;
  localparam int PBYTE_W = 6;

  function automatic logic [PBYTE_W-1:0] page_bytes(input logic [PSIZE_W-1:0] code);
    return PBYTE_W'(4) << code;
  endfunction
endpackage

// File: rtl/fdt_cfg_sel.sv
module fdt_cfg_sel #(
  parameter int NUM_CS = 4,
  parameter int W      = 4,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS*W-1:0] flat,
  input  logic [CSW-1:0]      idx,
  output logic [W-1:0]        val
);
  logic [W-1:0] fields [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign fields[g] = flat[g*W +: W];
  end

  always_comb begin
    val = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (CSW'(i) == idx) val = fields[i];
  end
endmodule

// File: rtl/fdt_edge.sv
module fdt_edge (
  input  logic clk,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) prev_q <= strobe;

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/fdt_window.sv
module fdt_window #(
  parameter int CW  = 5,
  parameter int CSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [CW-1:0]  load_val,
  input  logic [CSW-1:0] load_cs,
  input  logic           load_opt,
  output logic [CW-1:0]  rem,
  output logic [CSW-1:0] owner,
  output logic           opt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem   <= '0;
      owner <= '0;
      opt_q <= 1'b0;
    end else if (load) begin
      rem   <= load_val;
      owner <= load_cs;
      opt_q <= load_opt;
    end else if (rem != '0) begin
      rem <= rem - CW'(1);
    end
  end
endmodule

// File: rtl/fdt_gate.sv
module fdt_gate #(
  parameter int CW      = 5,
  parameter int CSW     = 2,
  parameter int SETUP_W = 6
) (
  input  logic               req_valid,
  input  logic [CSW-1:0]     req_cs,
  input  logic               req_write,
  input  logic [SETUP_W-1:0] req_setup,
  input  logic [CW-1:0]      rem,
  input  logic [CSW-1:0]     owner,
  input  logic               opt_q,
  output logic               req_ready
);
  logic exempt, covered, clear;

  assign exempt  = !req_write && (req_cs == owner);
  assign covered = opt_q && (32'(rem) <= 32'(req_setup));
  assign clear   = (rem == '0) || exempt || covered;

  assign req_ready = req_valid && clear;
endmodule

// File: rtl/turnaround_ctl.sv
module turnaround_ctl
  import fdt_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int SETUP_W = 6,
  localparam int CSW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CS*FLOAT_W-1:0] cfg_float,
  input  logic [NUM_CS-1:0]         cfg_opt,
  input  logic [NUM_CS-1:0]         cfg_page_en,
  input  logic [NUM_CS*PSIZE_W-1:0] cfg_page_size,
  input  logic                      rd_strobe,
  input  logic [CSW-1:0]            rd_cs,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [CSW-1:0]            req_cs,
  input  logic                      req_write,
  input  logic [SETUP_W-1:0]        req_setup,
  output logic                      float_busy,
  output logic                      acc_page_mode,
  output logic [PBYTE_W-1:0]        acc_page_bytes
);
  localparam int CW = FLOAT_W + 1;

  logic               rise;
  logic [FLOAT_W-1:0] rd_float;
  logic               rd_opt;
  logic [PSIZE_W-1:0] req_psize;
  logic [CW-1:0]      rem_q;
  logic [CSW-1:0]     owner_q;
  logic               opt_q;

  fdt_edge u_edge (.clk(clk), .strobe(rd_strobe), .rise(rise));

  fdt_cfg_sel #(.NUM_CS(NUM_CS), .W(FLOAT_W)) u_sel_float (
    .flat(cfg_float), .idx(rd_cs), .val(rd_float));

  fdt_cfg_sel #(.NUM_CS(NUM_CS), .W(1)) u_sel_opt (
    .flat(cfg_opt), .idx(rd_cs), .val(rd_opt));

  fdt_cfg_sel #(.NUM_CS(NUM_CS), .W(1)) u_sel_pmode (
    .flat(cfg_page_en), .idx(req_cs), .val(acc_page_mode));

  fdt_cfg_sel #(.NUM_CS(NUM_CS), .W(PSIZE_W)) u_sel_psize (
    .flat(cfg_page_size), .idx(req_cs), .val(req_psize));

  fdt_window #(.CW(CW), .CSW(CSW)) u_win (
    .clk(clk), .rst_n(rst_n), .load(rise),
    .load_val(CW'(rd_float) + CW'(1)), .load_cs(rd_cs), .load_opt(rd_opt),
    .rem(rem_q), .owner(owner_q), .opt_q(opt_q));

  fdt_gate #(.CW(CW), .CSW(CSW), .SETUP_W(SETUP_W)) u_gate (
    .req_valid(req_valid), .req_cs(req_cs), .req_write(req_write),
    .req_setup(req_setup), .rem(rem_q), .owner(owner_q), .opt_q(opt_q),
    .req_ready(req_ready));

  assign float_busy     = (rem_q != '0);
  assign acc_page_bytes = page_bytes(req_psize);
endmodule

// File: rtl/fdt_chk.sv
module fdt_chk #(
  parameter int CW      = 5,
  parameter int CSW     = 2,
  parameter int SETUP_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_strobe,
  input logic               req_valid,
  input logic               req_ready,
  input logic [CSW-1:0]     req_cs,
  input logic               req_write,
  input logic [SETUP_W-1:0] req_setup,
  input logic               float_busy,
  input logic [CW-1:0]      rem,
  input logic [CSW-1:0]     owner,
  input logic               opt_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !float_busy);

  // R2
  window_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_strobe) |=> float_busy);

  // R2
  window_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem != '0) && !$rose(rd_strobe) |=> rem == $past(rem) - CW'(1));

  // R3
  plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && float_busy && !opt_q && (req_write || req_cs != owner) |-> !req_ready);

  // R4
  overlap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && opt_q && (32'(rem) > 32'(req_setup)) && (req_write || req_cs != owner)
      |-> !req_ready);

  // R5
  owner_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_cs == owner |-> req_ready);

  // R7
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !float_busy |-> req_ready == req_valid);
endmodule

bind turnaround_ctl fdt_chk #(.CW(CW), .CSW(CSW), .SETUP_W(SETUP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .req_valid(req_valid),
  .req_ready(req_ready), .req_cs(req_cs), .req_write(req_write),
  .req_setup(req_setup), .float_busy(float_busy), .rem(rem_q),
  .owner(owner_q), .opt_q(opt_q));

// File: tb/sim_turnaround_ctl.sv
module sim_turnaround_ctl;
  localparam int NUM_CS  = 4;
  localparam int SETUP_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CS*4-1:0] cfg_float;
  logic [NUM_CS-1:0]   cfg_opt;
  logic [NUM_CS-1:0]   cfg_page_en;
  logic [NUM_CS*2-1:0] cfg_page_size;
  logic rd_strobe = 1'b1;
  logic [1:0] rd_cs = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_cs = '0;
  logic req_write = 1'b0;
  logic [SETUP_W-1:0] req_setup = '0;
  logic float_busy, acc_page_mode;
  logic [5:0] acc_page_bytes;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  turnaround_ctl #(.NUM_CS(NUM_CS), .SETUP_W(SETUP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_float(cfg_float), .cfg_opt(cfg_opt),
    .cfg_page_en(cfg_page_en), .cfg_page_size(cfg_page_size),
    .rd_strobe(rd_strobe), .rd_cs(rd_cs), .req_valid(req_valid),
    .req_ready(req_ready), .req_cs(req_cs), .req_write(req_write),
    .req_setup(req_setup), .float_busy(float_busy),
    .acc_page_mode(acc_page_mode), .acc_page_bytes(acc_page_bytes));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // Monitor: count refused cycles per request, compare against scoreboard.
  initial begin
    int stalls = 0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        if (req_ready) begin
          if (exp_q.size() == 0) check("scoreboard underrun", 1, 0);
          else check(tag_q.pop_front(), stalls, exp_q.pop_front());
          stalls = 0;
        end else stalls++;
      end
    end
  end

  task automatic issue(input logic [1:0] cs, input logic wr, input int s,
                       input int exp, input string tag);
    req_cs = cs; req_write = wr; req_setup = SETUP_W'(s);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    step();
    req_valid = 1'b0;
    repeat (20) step();
  endtask

  task automatic end_read(input logic [1:0] cs);
    rd_cs = cs; rd_strobe = 1'b0;
    step();
    rd_strobe = 1'b1;
    step();
  endtask

  task automatic read_then(input logic [1:0] rcs, input logic [1:0] qcs,
                           input logic wr, input int s, input int exp, input string tag);
    end_read(rcs);
    issue(qcs, wr, s, exp, tag);
  endtask

  initial begin
    // CS0 F=3 plain, CS1 F=5 overlap, CS2 F=0 plain, CS3 F=15 overlap
    cfg_float     = {4'd15, 4'd0, 4'd5, 4'd3};
    cfg_opt       = 4'b1010;
    cfg_page_en   = 4'b1010;
    cfg_page_size = {2'd3, 2'd2, 2'd1, 2'd0};
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(float_busy), 0);
    step();

    issue(2'd1, 1'b0, 0, 0, "R7 idle request");
    read_then(2'd0, 2'd1, 1'b0, 2, 4, "R3 F=3 foreign read");
    read_then(2'd2, 2'd0, 1'b0, 5, 1, "R3 F=0 turnaround only");
    read_then(2'd1, 2'd0, 1'b0, 2, 4, "R4 F=5 S=2");
    read_then(2'd1, 2'd2, 1'b0, 6, 0, "R4 F=5 S=6 fully covered");
    read_then(2'd1, 2'd3, 1'b0, 0, 6, "R4 F=5 S=0");
    read_then(2'd3, 2'd0, 1'b1, 4, 12, "R4 F=15 S=4 write");
    read_then(2'd0, 2'd0, 1'b0, 0, 0, "R5 owner read");
    read_then(2'd1, 2'd1, 1'b0, 0, 0, "R5 owner read overlap cs");
    read_then(2'd0, 2'd0, 1'b1, 0, 4, "R6 owner write");
    read_then(2'd0, 2'd2, 1'b1, 9, 4, "R6 write plain ignores setup");

    for (int i = 0; i < NUM_CS; i++) begin
      req_cs = 2'(i);
      @(negedge clk);
      check($sformatf("R8 page bytes cs%0d", i), int'(acc_page_bytes), 4 << i);
      check($sformatf("R8 page mode cs%0d", i), int'(acc_page_mode), (i % 2));
      step();
    end
    cfg_page_size = {2'd0, 2'd0, 2'd3, 2'd3};
    cfg_page_en   = 4'b1111;
    read_then(2'd0, 2'd1, 1'b0, 2, 4, "R8 page change no stall effect");

    end_read(2'd3);
    step();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy cleared mid window", int'(float_busy), 1 - 1);
    step();
    issue(2'd0, 1'b0, 0, 0, "R1 no stall after reset");

    check("scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule